// File: doc/BRIEF.md
# Three-Stage Packed Word Multiplier with Pairwise Accumulate

This block multiplies two 64-bit packed operands, each holding four signed 16-bit lanes, and returns a 64-bit packed result. A two-bit operation code selects what is returned. The low 16 bits of each lane's 32-bit product can be returned in place. The high 16 bits of each product can be returned in place. Or neighbouring lane products can be summed into two 32-bit results.

The unit is fully pipelined. It accepts a new operation on every clock, and each result appears exactly three rising edges after its operands are sampled. A valid flag and the operation code travel down the pipe beside the data, so consecutive operations of different kinds do not disturb one another. The unit has no stall and no back-pressure. A consumer must take results as they arrive.

Top module: `packed_mul3`

## Requirements
- R1: While reset is asserted, and on the first edges after reset is released, out_valid is 0 and out_data is 0.
- R2: out_valid equals the in_valid value sampled three rising edges earlier. Idle cycles (in_valid low) never produce a valid result.
- R3: Lane i occupies bits 16i+15:16i of in_a, in_b and out_data. With op code 2'b00, each lane of out_data holds bits 15:0 of the signed 32-bit product of the matching input lanes.
- R4: With op code 2'b01, each lane of out_data holds bits 31:16 of the signed product of the matching input lanes.
- R5: With op code 2'b10, out_data[31:0] is product0 + product1 and out_data[63:32] is product2 + product3, each sum taken modulo 2^32.
- R6: Op code 2'b11 gives the same result as 2'b10.
- R7: A new operation can be issued on every clock. Each operation's result is computed with its own op code, even when consecutive operations use different codes.
- R8: Summed results wrap on overflow. Two lane pairs of -32768 x -32768 give 0x80000000 in the affected doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op code are presented this cycle |
| in_mode | input | 2 | Op code: 00 low halves, 01 high halves, 1x pairwise sum |
| in_a | input | 64 | First packed operand, four signed 16-bit lanes |
| in_b | input | 64 | Second packed operand, four signed 16-bit lanes |
| out_valid | output | 1 | out_data holds a result this cycle |
| out_data | output | 64 | Packed result |

## Verification
A stage register that loses its valid or op code shows up at the ports exactly three edges after the issue that was damaged. The result is then a missing or extra out_valid pulse, or a lane that carries the wrong half or a sum in place of a product. Back-to-back issues that alternate op codes expose a stage that misaligns the code with the data on the very next result. Signed corner operands (-32768, 32767, -1) expose sign-extension and wrap faults in a single result.

// File: rtl/packed_mul3.sv
module packed_mul3 #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                in_mode,
  input  logic [LANE_W*LANES-1:0]   in_a,
  input  logic [LANE_W*LANES-1:0]   in_b,
  output logic                      out_valid,
  output logic [LANE_W*LANES-1:0]   out_data
);
  localparam int DW    = LANE_W * LANES;
  localparam int PW    = 2 * LANE_W;
  localparam int PAIRS = LANES / 2;

  logic          s1_v, s2_v;
  logic [1:0]    s1_m, s2_m;
  logic [DW-1:0] s1_a, s1_b;
  logic signed [PW-1:0] prod [LANES];
  logic signed [PW-1:0] s2_p [LANES];
  logic [DW-1:0] lo_w, hi_w, sum_w, res_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_m <= '0;
      s1_a <= '0;
      s1_b <= '0;
    end else begin
      s1_v <= in_valid;
      s1_m <= in_mode;
      s1_a <= in_a;
      s1_b <= in_b;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign prod[i] = $signed(s1_a[i*LANE_W +: LANE_W]) * $signed(s1_b[i*LANE_W +: LANE_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_p[i] <= '0;
      else        s2_p[i] <= prod[i];
    end

    assign lo_w[i*LANE_W +: LANE_W] = s2_p[i][LANE_W-1:0];
    assign hi_w[i*LANE_W +: LANE_W] = s2_p[i][PW-1:LANE_W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign sum_w[j*PW +: PW] = s2_p[2*j] + s2_p[2*j+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
      s2_m <= '0;
    end else begin
      s2_v <= s1_v;
      s2_m <= s1_m;
    end
  end

  assign res_w = (s2_m == 2'b00) ? lo_w :
                 (s2_m == 2'b01) ? hi_w : sum_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s2_v;
      out_data  <= res_w;
    end
  end
endmodule

// File: rtl/packed_mul3_chk.sv
module packed_mul3_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              in_mode,
  input logic [LANE_W*LANES-1:0] in_a,
  input logic [LANE_W*LANES-1:0] in_b,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] out_data
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  logic signed [2*LANE_W-1:0] p0_now, p1_now, s0_now;
  assign p0_now = $signed(in_a[LANE_W-1:0]) * $signed(in_b[LANE_W-1:0]);
  assign p1_now = $signed(in_a[2*LANE_W-1:LANE_W]) * $signed(in_b[2*LANE_W-1:LANE_W]);
  assign s0_now = p0_now + p1_now;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_data == '0));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_low_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_mode, 3) == 2'b00)
      |-> (out_data[LANE_W-1:0] == $past(p0_now[LANE_W-1:0], 3)));

  a_r4_high_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_mode, 3) == 2'b01)
      |-> (out_data[LANE_W-1:0] == $past(p0_now[2*LANE_W-1:LANE_W], 3)));

  a_r5_sum_low: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_mode[1], 3))
      |-> (out_data[2*LANE_W-1:0] == $past(s0_now, 3)));
endmodule

bind packed_mul3 packed_mul3_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/packed_mul3_bench.sv
module packed_mul3_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'b00;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;
  logic        q_v[$];
  logic [1:0]  q_m[$];
  logic [63:0] q_d[$];

  always #10 clk = ~clk;

  packed_mul3 u_packed_mul3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int p[4];
    for (int i = 0; i < 4; i++) begin
      shortint x = shortint'(a[16*i +: 16]);
      shortint y = shortint'(b[16*i +: 16]);
      p[i] = int'(x) * int'(y);
    end
    case (m)
      2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
      2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
      default: begin
        int s0 = p[0] + p[1];
        int s1 = p[2] + p[3];
        r = {s1, s0};
      end
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R3/R7";
      2'b01: return "R4/R7";
      2'b10: return "R5/R8";
      default: return "R6";
    endcase
  endfunction

  task automatic issue(input logic v, input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    in_valid = v; in_mode = m; in_a = a; in_b = b;
    q_v.push_back(v); q_m.push_back(m); q_d.push_back(model(m, a, b));
    @(negedge clk);
    if (q_v.size() == 3) begin
      logic ev = q_v.pop_front();
      logic [1:0] em = q_m.pop_front();
      logic [63:0] ed = q_d.pop_front();
      total++;
      if (out_valid !== ev) begin
        bad++;
        $display("FAIL R2: out_valid=%0b expected=%0b", out_valid, ev);
      end
      if (ev) begin
        total++;
        if (out_data !== ed) begin
          bad++;
          $display("FAIL %s: out_data=%h expected=%h", req_of(em), out_data, ed);
        end
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_data !== 64'h0) begin
      bad++;
      $display("FAIL R1: valid=%0b data=%h expected 0/0", out_valid, out_data);
    end
    rst_n = 1'b1;
    total++;
    if (out_valid !== 1'b0 || out_data !== 64'h0) begin
      bad++;
      $display("FAIL R1: after release valid=%0b data=%h expected 0/0", out_valid, out_data);
    end
    // R3 R4 R5 R6 signed corners
    issue(1, 2'b00, 64'h8000_7fff_ffff_0003, 64'h8000_7fff_ffff_fffd);
    issue(1, 2'b01, 64'h8000_7fff_ffff_0003, 64'h8000_7fff_ffff_fffd);
    issue(1, 2'b10, 64'h8000_8000_7fff_ffff, 64'h8000_8000_7fff_0001);
    issue(1, 2'b11, 64'h8000_8000_7fff_ffff, 64'h8000_8000_7fff_0001);
    // R2 idle cycles produce nothing
    issue(0, 2'b00, 64'h1234_5678_9abc_def0, 64'h1111_2222_3333_4444);
    issue(0, 2'b10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    // R8 doubleword wrap on both halves
    issue(1, 2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    issue(1, 2'b01, 64'h0000_0001_ffff_8000, 64'h0000_ffff_ffff_0002);
    // R7 alternating op codes back to back
    for (int k = 0; k < 16; k++)
      issue(1, 2'(k), {16'(k * 977), 16'(-k), 16'(k * 4099), 16'h8000},
                      {16'(k * 31), 16'h7fff, 16'(-k * 13), 16'(k)});
    for (int k = 0; k < 600; k++)
      issue(($urandom % 4) != 0, 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    for (int k = 0; k < 3; k++) issue(0, 2'b00, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule